// File: doc/BRIEF.md
# Dataflow Logic Cell with Neighbour Token Handshakes

This block is one cell of a lattice of identical cells that pass single-bit tokens between neighbours. Each cell evaluates one two-input Boolean function, but it does not evaluate continuously. It fires only when both of its operands hold a token and every output slot it drives is empty. When it fires, it consumes the operand tokens and writes one result token into every enabled output slot in the same cycle. Every token link is a synchronous valid/ready pair, so asynchronous token flow can be modelled inside a clocked design.

Each operand is fed from one of six neighbour directions, or from none. Results fan out to any subset of the six directions. A transport mode turns the cell into a bufferless connection: one source is broadcast to the masked directions, and a second source crosses straight through to the opposite side. A configuration word selects the function, the two sources, the output mask and an optional initial token for each operand. It is written through a one-cycle write strobe while the cell is idle.

Top module: `lattice_cell`

## Requirements
- R1: During and after reset, before any configuration write, every `out_valid` bit and every `in_ready` bit is 0.
- R2: The cell fires only when every used operand holds a token and every enabled output slot is empty. An operand that holds a token keeps it until the cell fires, and its source direction's `in_ready` stays 0 meanwhile. A result appears on `out_valid` in the cycle after the cell fires.
- R3: The function field `cfg_data[2:0]` selects the operation: 000 = AND, 001 = NAND, 010 = OR, 011 = XOR, 100 = transport.
- R4: The operand A source is `cfg_data[5:3]` and the operand B source is `cfg_data[8:6]`. Their codes are: 000 forward, 001 backward, 010 right, 011 left, 101 up, 110 down, 111 (and 100) unused. On the port vectors, bit 0..5 stand for forward, backward, right, left, up, down. In gate mode `in_ready` is asserted only on the selected source directions of operands that are empty.
- R5: The initial-token fields are `cfg_data[10:9]` for operand A and `cfg_data[12:11]` for operand B. The code 00 preloads a token of value 0, 01 preloads a token of value 1, and 10 (or 11) leaves the operand empty. A preloaded token counts as present for the firing rule.
- R6: An unused operand is always satisfied and takes the value of the other operand, so a NAND with one source acts as an inverter. With both operands unused the cell never fires.
- R7: When both operands select the same direction, one accepted token fills both operands. AND in this form is therefore a one-stage buffer.
- R8: The output mask is `cfg_data[18:13]`, one bit per direction. On a fire the result is written to every enabled slot in the same cycle. Each slot holds its token and value until its own `out_ready` takes it, and the cell does not fire again until all enabled slots are empty.
- R9: In transport mode, operand A's source is passed combinationally to every masked output, and is accepted only when all masked outputs are ready. Operand B's source passes combinationally to the direction opposite to it (forward/backward, right/left, up/down). Nothing is stored.
- R10: A configuration write empties every output slot and loads the operands from the new initial-token fields. The function codes 101, 110 and 111 leave the cell inert: it never fires and `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 19 | Configuration word (fields per R3, R4, R5, R8) |
| in_valid | input | 6 | Token offered by each neighbour |
| in_data | input | 6 | Token value from each neighbour |
| in_ready | output | 6 | Cell accepts the offered token from that neighbour |
| out_valid | output | 6 | Result token present toward each neighbour |
| out_data | output | 6 | Result token value toward each neighbour |
| out_ready | input | 6 | Neighbour takes the result token |

## Verification
The assertions assume three things about the cell's environment. Configuration is written only while no token is in flight. A neighbour holds its token and value steady until it is accepted. In transport mode the crossing direction is not also set in the output mask. The stimulus keeps to all three: every configuration write happens with all inputs idle, each offered token stays up until it is taken and is dropped right after, and the transport case uses a crossing direction outside the mask.

// File: rtl/lattice_pkg.sv
package lattice_pkg;
  localparam int NDIR   = 6;
  localparam int IDX_W  = 3;
  localparam int CFG_W  = 19;

  typedef enum logic [2:0] {
    FN_AND   = 3'b000,
    FN_NAND  = 3'b001,
    FN_OR    = 3'b010,
    FN_XOR   = 3'b011,
    FN_PASS  = 3'b100
  } fn_e;

  typedef struct packed {
    logic [NDIR-1:0] mask;
    logic [1:0]      init_b;
    logic [1:0]      init_a;
    logic [2:0]      src_b;
    logic [2:0]      src_a;
    logic [2:0]      fn;
  } cell_cfg_t;

  // direction code -> port bit index; returns 7 when unused
  function automatic logic [IDX_W-1:0] dir_index(input logic [2:0] code);
    case (code)
      3'b000: return 3'd0;
      3'b001: return 3'd1;
      3'b010: return 3'd2;
      3'b011: return 3'd3;
      3'b101: return 3'd4;
      3'b110: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/lattice_operand.sv
module lattice_operand (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] init,
  input  logic       take,
  input  logic       tok,
  input  logic       consume,
  output logic       full,
  output logic       val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      val  <= 1'b0;
    end else if (load) begin
      full <= ~init[1];
      val  <= init[0];
    end else if (take) begin
      full <= 1'b1;
      val  <= tok;
    end else if (consume) begin
      full <= 1'b0;
    end
  end

  assert_held_R2: assert property (@(posedge clk) disable iff (rst)
    full && !consume && !load |=> full && $stable(val));
  assert_consume_empties_R2: assert property (@(posedge clk) disable iff (rst)
    full && consume && !load |=> !full);
  assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> !full);
endmodule

// File: rtl/lattice_slot.sv
module lattice_slot (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic valid,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid <= 1'b0;
      dout  <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end

  assert_push_empty_R8: assert property (@(posedge clk) disable iff (rst)
    push && !clr |-> !valid);
  assert_slot_hold_R8: assert property (@(posedge clk) disable iff (rst)
    valid && !pop && !clr |=> valid && $stable(dout));
endmodule

// File: rtl/lattice_logic.sv
module lattice_logic
  import lattice_pkg::*;
(
  input  logic [2:0] fn,
  input  logic       a,
  input  logic       b,
  output logic       y
);
  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_NAND: y = ~(a & b);
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/lattice_cell.sv
module lattice_cell
  import lattice_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic [NDIR-1:0]     in_valid,
  input  logic [NDIR-1:0]     in_data,
  output logic [NDIR-1:0]     in_ready,
  output logic [NDIR-1:0]     out_valid,
  output logic [NDIR-1:0]     out_data,
  input  logic [NDIR-1:0]     out_ready
);
  cell_cfg_t cfg, cfg_new;
  assign cfg_new = cell_cfg_t'(cfg_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{mask: '0, init_b: 2'b10, init_a: 2'b10,
               src_b: 3'b111, src_a: 3'b111, fn: 3'b000};
    end else if (cfg_we) begin
      cfg <= cfg_new;
    end
  end

  logic [IDX_W-1:0] ia, ib, opp_b;
  logic a_used, b_used, same_src, gate_mode, pass_mode;
  assign ia        = dir_index(cfg.src_a);
  assign ib        = dir_index(cfg.src_b);
  assign a_used    = (ia != 3'd7);
  assign b_used    = (ib != 3'd7);
  assign opp_b     = ib ^ 3'd1;
  assign same_src  = a_used && b_used && (ia == ib);
  assign gate_mode = (cfg.fn[2] == 1'b0);
  assign pass_mode = (cfg.fn == FN_PASS);

  // operands
  logic a_full, b_full, a_val, b_val;
  logic take_a, take_b, tok_b, fire;
  logic a_rdy, b_rdy;

  assign a_rdy  = gate_mode && a_used && !a_full && (!same_src || !b_full);
  assign b_rdy  = gate_mode && b_used && !b_full && !same_src;
  assign take_a = a_rdy && in_valid[ia];
  assign take_b = same_src ? take_a : (b_rdy && in_valid[ib]);
  assign tok_b  = same_src ? in_data[ia] : in_data[ib];

  lattice_operand u_opa (
    .clk(clk), .rst(rst), .load(cfg_we), .init(cfg_new.init_a),
    .take(take_a), .tok(in_data[ia]), .consume(fire && a_used),
    .full(a_full), .val(a_val));

  lattice_operand u_opb (
    .clk(clk), .rst(rst), .load(cfg_we), .init(cfg_new.init_b),
    .take(take_b), .tok(tok_b), .consume(fire && b_used),
    .full(b_full), .val(b_val));

  logic op_a, op_b, result;
  assign op_a = a_used ? a_val : b_val;
  assign op_b = b_used ? b_val : a_val;

  lattice_logic u_fn (.fn(cfg.fn), .a(op_a), .b(op_b), .y(result));

  logic [NDIR-1:0] slot_v, slot_d;
  assign fire = gate_mode && !cfg_we && (a_used || b_used)
             && (!a_used || a_full) && (!b_used || b_full)
             && ((slot_v & cfg.mask) == '0);

  for (genvar d = 0; d < NDIR; d++) begin : g_slot
    lattice_slot u_slot (
      .clk(clk), .rst(rst), .clr(cfg_we),
      .push(fire && cfg.mask[d]), .din(result),
      .pop(out_ready[d]), .valid(slot_v[d]), .dout(slot_d[d]));
  end

  // bufferless transport paths
  logic all_rdy;
  logic [NDIR-1:0] pv, pd, pr;
  assign all_rdy = ((out_ready | ~cfg.mask) == '1) && (cfg.mask != '0);

  always_comb begin
    pv = '0;
    pd = '0;
    pr = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (a_used && cfg.mask[d]) begin
        pv[d] = in_valid[ia] && all_rdy;
        pd[d] = in_data[ia];
      end
      if (b_used && opp_b == d[IDX_W-1:0]) begin
        pv[d] = in_valid[ib];
        pd[d] = in_data[ib];
      end
    end
    if (a_used) pr[ia] = all_rdy;
    if (b_used) pr[ib] = out_ready[opp_b];
  end

  always_comb begin
    in_ready = '0;
    if (pass_mode) begin
      in_ready = pr;
    end else begin
      if (a_used) in_ready[ia] = a_rdy;
      if (b_used && !same_src) in_ready[ib] = b_rdy;
    end
  end

  assign out_valid = pass_mode ? pv : slot_v;
  assign out_data  = pass_mode ? pd : slot_d;

  assert_fanout_R8: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((out_valid & $past(cfg.mask)) == $past(cfg.mask)));
  assert_ready_sources_R4: assert property (@(posedge clk) disable iff (rst)
    !pass_mode |-> $countones(in_ready) <= 2);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) && !$past(cfg_we) |-> out_valid == '0 && in_ready == '0);
  assert_inert_R10: assert property (@(posedge clk) disable iff (rst)
    !gate_mode && !pass_mode |=> $stable(slot_v) || $past(cfg_we));
endmodule

// File: tb/lattice_cell_bench.sv
module lattice_cell_bench;
  logic clk = 0;
  logic rst = 1;
  logic cfg_we = 0;
  logic [18:0] cfg_data = '0;
  logic [5:0] in_valid = '0, in_data = '0, out_ready = '0;
  logic [5:0] in_ready, out_valid, out_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lattice_cell u_lattice_cell (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk(logic [2:0] fn, logic [2:0] sa, logic [2:0] sb,
                                     logic [1:0] ia, logic [1:0] ib, logic [5:0] m);
    return {m, ib, ia, sb, sa, fn};
  endfunction

  task automatic configure(logic [18:0] w);
    cfg_data = w; cfg_we = 1; tick(); cfg_we = 0;
  endtask

  task automatic send(int d, logic v);
    in_valid[d] = 1; in_data[d] = v; tick(); in_valid[d] = 0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 6'b0);
    chk("R1 in_ready", in_ready, 6'b0);
  endtask

  // all functions via preloaded operands, result toward up (bit 4)
  task automatic t_functions();
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 4; k++) begin
        logic a, b, e;
        a = k[0]; b = k[1];
        case (f)
          0: e = a & b;
          1: e = ~(a & b);
          2: e = a | b;
          default: e = a ^ b;
        endcase
        configure(mk(f[2:0], 3'b000, 3'b010, {1'b0, a}, {1'b0, b}, 6'b010000));
        chk("R2 no result yet", out_valid, 6'b0);
        tick();
        chk("R3 R5 valid", out_valid, 6'b010000);
        chk("R3 function value", {5'b0, out_data[4]}, {5'b0, e});
        out_ready = 6'b010000; tick(); out_ready = 0;
      end
    end
  endtask

  task automatic t_handshake();
    configure(mk(3'b000, 3'b000, 3'b010, 2'b10, 2'b10, 6'b010000));
    chk("R4 ready on sources", in_ready, 6'b000101);
    send(0, 1);
    chk("R2 one operand", out_valid, 6'b0);
    chk("R2 ready drops", in_ready, 6'b000100);
    tick();
    chk("R2 still waiting", out_valid, 6'b0);
    send(2, 1);
    chk("R2 fire pending", out_valid, 6'b0);
    tick();
    chk("R2 R3 AND result", {out_valid[4], out_data[4]}, 2'b11);
    out_ready = 6'b010000; tick(); out_ready = 0;
    configure(mk(3'b000, 3'b000, 3'b010, 2'b10, 2'b10, 6'b010000));
    tick(); tick();
    chk("R5 empty preload", out_valid, 6'b0);
  endtask

  task automatic t_single();
    configure(mk(3'b001, 3'b011, 3'b111, 2'b10, 2'b10, 6'b000010));
    chk("R6 ready left only", in_ready, 6'b001000);
    send(3, 1); tick();
    chk("R6 inverter of 1", {out_valid[1], out_data[1]}, 2'b10);
    out_ready = 6'b000010; tick(); out_ready = 0;
    send(3, 0); tick();
    chk("R6 inverter of 0", {out_valid[1], out_data[1]}, 2'b11);
    out_ready = 6'b000010; tick(); out_ready = 0;
    configure(mk(3'b000, 3'b111, 3'b111, 2'b01, 2'b01, 6'b000001));
    tick(); tick();
    chk("R6 no sources", out_valid, 6'b0);
  endtask

  task automatic t_buffer();
    configure(mk(3'b000, 3'b110, 3'b110, 2'b10, 2'b10, 6'b000001));
    chk("R7 ready down", in_ready, 6'b100000);
    send(5, 1); tick();
    chk("R7 buffered 1", {out_valid[0], out_data[0]}, 2'b11);
    out_ready = 6'b000001; tick(); out_ready = 0;
    send(5, 0); tick();
    chk("R7 buffered 0", {out_valid[0], out_data[0]}, 2'b10);
    out_ready = 6'b000001; tick(); out_ready = 0;
  endtask

  task automatic t_fanout();
    configure(mk(3'b000, 3'b011, 3'b011, 2'b10, 2'b10, 6'b010101));
    send(3, 1); tick();
    chk("R8 all enabled", out_valid, 6'b010101);
    chk("R8 values", out_data & 6'b010101, 6'b010101);
    send(3, 0); tick(); tick();
    chk("R8 blocked", out_valid, 6'b010101);
    chk("R8 values held", out_data & 6'b010101, 6'b010101);
    chk("R2 operand held", in_ready, 6'b0);
    out_ready = 6'b000001; tick(); out_ready = 0;
    chk("R8 one taken", out_valid, 6'b010100);
    tick();
    chk("R8 still blocked", out_valid, 6'b010100);
    out_ready = 6'b010100; tick(); out_ready = 0;
    chk("R8 drained", out_valid, 6'b0);
    tick();
    chk("R8 refire", out_valid, 6'b010101);
    chk("R8 refire values", out_data & 6'b010101, 6'b0);
  endtask

  task automatic t_transport();
    out_ready = 0;
    configure(mk(3'b100, 3'b001, 3'b101, 2'b10, 2'b10, 6'b000101));
    out_ready = 6'b100101;
    in_valid = 6'b010010; in_data = 6'b000010;
    #1;
    chk("R9 pass valid", out_valid, 6'b100101);
    chk("R9 pass data", out_data, 6'b000101);
    chk("R9 pass ready", in_ready, 6'b010010);
    out_ready = 6'b100001;
    #1;
    chk("R9 broadcast stalls", out_valid, 6'b100000);
    chk("R9 source stalls", in_ready, 6'b010000);
    in_valid = 0; in_data = 0; out_ready = 0;
    tick();
  endtask

  task automatic t_config();
    configure(mk(3'b101, 3'b000, 3'b010, 2'b01, 2'b01, 6'b000001));
    tick(); tick();
    chk("R10 inert output", out_valid, 6'b0);
    chk("R10 inert ready", in_ready, 6'b0);
    configure(mk(3'b010, 3'b000, 3'b010, 2'b01, 2'b00, 6'b000001));
    tick();
    chk("R10 slot filled", out_valid, 6'b000001);
    configure(mk(3'b010, 3'b000, 3'b010, 2'b10, 2'b10, 6'b000001));
    chk("R10 write clears", out_valid, 6'b0);
    chk("R10 operands empty", in_ready, 6'b000101);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 0;
    tick();
    t_reset();
    t_functions();
    t_handshake();
    t_single();
    t_buffer();
    t_fanout();
    t_transport();
    t_config();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule